// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Per-Port Output Mode

This block is a true dual-port memory of 18-bit words. Each port has its own clock and can read or write any location while the other port does the same. A port accepts an address, write data, two chip enables (one active low, one active high), a read/write line and two active-low byte selects. One select covers the upper 9-bit half of the word and the other covers the lower half. Address and control are captured on the rising edge of the port clock.

Read data leaves each port as a word plus a two-bit drive enable, one bit per half, in place of bidirectional pins. A static mode input on each port chooses the read path. In flow-through mode the word is valid after the edge that captured the read. In pipelined mode one more register adds a cycle of latency. The byte selects pass through one register stage in both modes. The read-enable derived from the chip enables passes through one stage in flow-through mode and two stages in pipelined mode. A separate active-low output enable removes drive at once, without waiting for a clock.

Depth is set by `ADDR_W`. Production builds use 14 or 15. The default is kept small so that the array stays small when elaborated.

Top module: `dpram_top`

## Requirements
- R1: A port is selected only while its active-low chip enable is 0 and its active-high chip enable is 1. A command captured while deselected writes nothing and leaves that port's drive enables at 0.
- R2: Bit 1 of the drive enable and the upper select (active low) control word bits 17 to 9. Bit 0 and the lower select control bits 8 to 0. A read with only one select active drives only that half.
- R3: On a rising edge with the port selected and read/write at 0, exactly the halves whose select is 0 are written. With both selects at 1, nothing is written.
- R4: In flow-through mode a read captured at edge k gives the stored word and drive enable 2'b11 (both selects active) before edge k+1.
- R5: In pipelined mode the same read appears one edge later, after edge k+1. Under one command stream, the pipelined port's output always equals the flow-through port's output of the previous cycle.
- R6: The drive enable bit of a half follows the byte select captured at the most recent edge, in both modes. In pipelined mode, a read at edge k followed at edge k+1 by an upper-only select drives 2'b10 after edge k+1.
- R7: In pipelined mode, a deselect captured at edge k removes drive only after edge k+1. Reselecting at edge j restores drive only after edge j+1. In flow-through mode both changes take effect after the capturing edge.
- R8: While a port's output enable is 1, its drive enables are 0 at once, with no clock edge needed. Clearing it restores the clocked state.
- R9: A word written by one port is read back by the other port in any later cycle. When each port writes a different half of one address, the word holds both halves.
- R10: After reset, both ports' drive enables are 0.
- R11: A write cycle is not a read. In flow-through mode, the drive enables are 0 after the edge that captures a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low asynchronous reset of the output staging registers |
| clk_a | input | 1 | Port A clock |
| ce0_a_n | input | 1 | Port A chip enable, active low |
| ce1_a | input | 1 | Port A chip enable, active high |
| rw_a | input | 1 | Port A read (1) / write (0) |
| ub_a_n | input | 1 | Port A upper-half select, active low |
| lb_a_n | input | 1 | Port A lower-half select, active low |
| oe_a_n | input | 1 | Port A asynchronous output enable, active low |
| pipe_a | input | 1 | Port A static mode: 1 pipelined, 0 flow-through |
| addr_a | input | ADDR_W | Port A word address |
| wdata_a | input | 18 | Port A write word |
| rdata_a | output | 18 | Port A read word |
| rden_a | output | 2 | Port A drive enable, bit 1 upper half, bit 0 lower half |
| clk_b | input | 1 | Port B clock |
| ce0_b_n | input | 1 | Port B chip enable, active low |
| ce1_b | input | 1 | Port B chip enable, active high |
| rw_b | input | 1 | Port B read (1) / write (0) |
| ub_b_n | input | 1 | Port B upper-half select, active low |
| lb_b_n | input | 1 | Port B lower-half select, active low |
| oe_b_n | input | 1 | Port B asynchronous output enable, active low |
| pipe_b | input | 1 | Port B static mode: 1 pipelined, 0 flow-through |
| addr_b | input | ADDR_W | Port B word address |
| wdata_b | input | 18 | Port B write word |
| rdata_b | output | 18 | Port B read word |
| rden_b | output | 2 | Port B drive enable, bit 1 upper half, bit 0 lower half |

## Verification
A write lands at the edge that captures it. A flow-through read is due in the half cycle after its capturing edge. A pipelined read, and a pipelined chip-enable change, is due one full cycle later. A byte-select change is due after one edge in either mode. The output enable acts within a nanosecond, with no edge between stimulus and check. The bench drives every input on the falling edge and samples on the next falling edge, so each check lands exactly one capture edge after its stimulus, or two where the pipelined path is under test. For the two-mode comparison, both ports are fed the same read stream and the bench checks the one-cycle offset on every cycle.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
    localparam int HALF_W   = 9;
    localparam int NUM_HALF = 2;
    localparam int WORD_W   = HALF_W * NUM_HALF;

    typedef logic [NUM_HALF-1:0] half_mask_t;
    typedef logic [WORD_W-1:0]   word_t;
endpackage

// File: rtl/dpram_array.sv
module dpram_array
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk_a,
    input  half_mask_t        we_a,
    input  logic [ADDR_W-1:0] waddr_a,
    input  word_t             wdata_a,
    input  logic [ADDR_W-1:0] raddr_a,
    output word_t             rdata_a,
    input  logic              clk_b,
    input  half_mask_t        we_b,
    input  logic [ADDR_W-1:0] waddr_b,
    input  word_t             wdata_b,
    input  logic [ADDR_W-1:0] raddr_b,
    output word_t             rdata_b
);
    localparam int DEPTH = 1 << ADDR_W;

    // Each half has one bank per port. A live-value bit pair per word
    // records which port wrote that half last, so that each bank has
    // a single writer clock.
    for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
        logic [HALF_W-1:0] bank_a [DEPTH];
        logic [HALF_W-1:0] bank_b [DEPTH];
        logic              live_a [DEPTH];
        logic              live_b [DEPTH];

        always_ff @(posedge clk_a) begin
            if (we_a[h]) begin
                bank_a[waddr_a] <= wdata_a[h*HALF_W +: HALF_W];
                live_a[waddr_a] <= live_b[waddr_a];
            end
        end

        always_ff @(posedge clk_b) begin
            if (we_b[h]) begin
                bank_b[waddr_b] <= wdata_b[h*HALF_W +: HALF_W];
                live_b[waddr_b] <= ~live_a[waddr_b];
            end
        end

        // Live bits differ -> port B holds the newest copy.
        assign rdata_a[h*HALF_W +: HALF_W] =
            (live_a[raddr_a] ^ live_b[raddr_a]) ? bank_b[raddr_a] : bank_a[raddr_a];
        assign rdata_b[h*HALF_W +: HALF_W] =
            (live_a[raddr_b] ^ live_b[raddr_b]) ? bank_b[raddr_b] : bank_a[raddr_b];
    end
endmodule

// File: rtl/dpram_port.sv
module dpram_port
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce0_n,
    input  logic              ce1,
    input  logic              rw,
    input  logic              ub_n,
    input  logic              lb_n,
    input  logic              oe_n,
    input  logic              pipe,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             arr_word,
    output logic [ADDR_W-1:0] arr_addr,
    output half_mask_t        wr_be,
    output word_t             dout,
    output half_mask_t        den
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              rd1;    // read enable after one stage
        logic              rd2;    // read enable after two stages
        half_mask_t        bsel;   // byte selects, single stage
        word_t             dpipe;  // extra read register for pipelined mode
    } stage_t;

    stage_t st_d, st_q;
    logic   sel;
    logic   drive;

    assign sel   = ~ce0_n & ce1;
    assign wr_be = {NUM_HALF{sel & ~rw}} & {~ub_n, ~lb_n};

    always_comb begin
        st_d       = st_q;
        st_d.addr  = addr;
        st_d.rd1   = sel & rw;
        st_d.rd2   = st_q.rd1;
        st_d.bsel  = {~ub_n, ~lb_n};
        st_d.dpipe = arr_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign arr_addr = st_q.addr;
    assign drive    = ~oe_n & (pipe ? st_q.rd2 : st_q.rd1);
    assign dout     = pipe ? st_q.dpipe : arr_word;
    assign den      = {NUM_HALF{drive}} & st_q.bsel;
endmodule

// File: rtl/dpram_top.sv
module dpram_top
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              rst_n,
    input  logic              clk_a,
    input  logic              ce0_a_n,
    input  logic              ce1_a,
    input  logic              rw_a,
    input  logic              ub_a_n,
    input  logic              lb_a_n,
    input  logic              oe_a_n,
    input  logic              pipe_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [17:0]       wdata_a,
    output logic [17:0]       rdata_a,
    output logic [1:0]        rden_a,
    input  logic              clk_b,
    input  logic              ce0_b_n,
    input  logic              ce1_b,
    input  logic              rw_b,
    input  logic              ub_b_n,
    input  logic              lb_b_n,
    input  logic              oe_b_n,
    input  logic              pipe_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [17:0]       wdata_b,
    output logic [17:0]       rdata_b,
    output logic [1:0]        rden_b
);
    logic [ADDR_W-1:0] raddr_a, raddr_b;
    half_mask_t        we_a, we_b;
    word_t             arr_a, arr_b;

    dpram_port #(.ADDR_W(ADDR_W)) u_port_a (
        .clk(clk_a), .rst_n(rst_n), .ce0_n(ce0_a_n), .ce1(ce1_a), .rw(rw_a),
        .ub_n(ub_a_n), .lb_n(lb_a_n), .oe_n(oe_a_n), .pipe(pipe_a),
        .addr(addr_a), .arr_word(arr_a), .arr_addr(raddr_a), .wr_be(we_a),
        .dout(rdata_a), .den(rden_a)
    );

    dpram_port #(.ADDR_W(ADDR_W)) u_port_b (
        .clk(clk_b), .rst_n(rst_n), .ce0_n(ce0_b_n), .ce1(ce1_b), .rw(rw_b),
        .ub_n(ub_b_n), .lb_n(lb_b_n), .oe_n(oe_b_n), .pipe(pipe_b),
        .addr(addr_b), .arr_word(arr_b), .arr_addr(raddr_b), .wr_be(we_b),
        .dout(rdata_b), .den(rden_b)
    );

    dpram_array #(.ADDR_W(ADDR_W)) u_array (
        .clk_a(clk_a), .we_a(we_a), .waddr_a(addr_a), .wdata_a(wdata_a),
        .raddr_a(raddr_a), .rdata_a(arr_a),
        .clk_b(clk_b), .we_b(we_b), .waddr_b(addr_b), .wdata_b(wdata_b),
        .raddr_b(raddr_b), .rdata_b(arr_b)
    );
endmodule

// File: rtl/dpram_chk.sv
module dpram_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ce0_n,
    input logic       ce1,
    input logic       rw,
    input logic       ub_n,
    input logic       lb_n,
    input logic       oe_n,
    input logic       pipe,
    input logic [1:0] den
);
    AST_OE_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> den == 2'b00); // R8

    AST_UPPER_FOLLOWS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        den[1] |-> $past(!ub_n)); // R6

    AST_LOWER_FOLLOWS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        den[0] |-> $past(!lb_n)); // R2

    AST_FT_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe && $past(ce0_n || !ce1)) |-> den == 2'b00); // R1

    AST_PIPE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe && $past(ce0_n || !ce1) && $past(ce0_n || !ce1, 2)) |-> den == 2'b00); // R7

    AST_FT_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe && $past(!rw)) |-> den == 2'b00); // R11
endmodule

bind dpram_top dpram_chk u_chk_a (
    .clk(clk_a), .rst_n(rst_n), .ce0_n(ce0_a_n), .ce1(ce1_a), .rw(rw_a),
    .ub_n(ub_a_n), .lb_n(lb_a_n), .oe_n(oe_a_n), .pipe(pipe_a), .den(rden_a)
);

bind dpram_top dpram_chk u_chk_b (
    .clk(clk_b), .rst_n(rst_n), .ce0_n(ce0_b_n), .ce1(ce1_b), .rw(rw_b),
    .ub_n(ub_b_n), .lb_n(lb_b_n), .oe_n(oe_b_n), .pipe(pipe_b), .den(rden_b)
);

// File: tb/dpram_top_tb.sv
module dpram_top_tb;
    localparam int AW = 9;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ce0_a_n, ce1_a, rw_a, ub_a_n, lb_a_n, oe_a_n, pipe_a;
    logic          ce0_b_n, ce1_b, rw_b, ub_b_n, lb_b_n, oe_b_n, pipe_b;
    logic [AW-1:0] addr_a, addr_b;
    logic [17:0]   wdata_a, wdata_b, rdata_a, rdata_b;
    logic [1:0]    rden_a, rden_b;

    int checks   = 0;
    int failures = 0;
    logic [17:0] ref_mem [0:(1<<AW)-1];

    always #4 clk = ~clk;

    dpram_top #(.ADDR_W(AW)) u_dut (
        .rst_n(rst_n),
        .clk_a(clk), .ce0_a_n(ce0_a_n), .ce1_a(ce1_a), .rw_a(rw_a),
        .ub_a_n(ub_a_n), .lb_a_n(lb_a_n), .oe_a_n(oe_a_n), .pipe_a(pipe_a),
        .addr_a(addr_a), .wdata_a(wdata_a), .rdata_a(rdata_a), .rden_a(rden_a),
        .clk_b(clk), .ce0_b_n(ce0_b_n), .ce1_b(ce1_b), .rw_b(rw_b),
        .ub_b_n(ub_b_n), .lb_b_n(lb_b_n), .oe_b_n(oe_b_n), .pipe_b(pipe_b),
        .addr_b(addr_b), .wdata_b(wdata_b), .rdata_b(rdata_b), .rden_b(rden_b)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // en: select, wr: write cycle, bs: {upper,lower} active-high selects
    task automatic drv_a(bit en, bit wr, bit [1:0] bs, int ad, logic [17:0] d);
        ce0_a_n = !en; ce1_a = 1'b1; rw_a = !wr;
        ub_a_n = !bs[1]; lb_a_n = !bs[0];
        addr_a = AW'(ad); wdata_a = d;
    endtask

    task automatic drv_b(bit en, bit wr, bit [1:0] bs, int ad, logic [17:0] d);
        ce0_b_n = !en; ce1_b = 1'b1; rw_b = !wr;
        ub_b_n = !bs[1]; lb_b_n = !bs[0];
        addr_b = AW'(ad); wdata_b = d;
    endtask

    task automatic idle_both();
        drv_a(0, 0, 2'b11, 0, '0);
        drv_b(0, 0, 2'b11, 0, '0);
    endtask

    task automatic ref_write(int ad, bit [1:0] bs, logic [17:0] d);
        if (bs[1]) ref_mem[ad][17:9] = d[17:9];
        if (bs[0]) ref_mem[ad][8:0]  = d[8:0];
    endtask

    task automatic wr_a(int ad, bit [1:0] bs, logic [17:0] d);
        drv_a(1, 1, bs, ad, d); ref_write(ad, bs, d); step(); drv_a(0, 0, 2'b11, 0, '0);
    endtask

    task automatic t_reset();
        check("R10 reset den_a", 32'(rden_a), 32'h0);
        check("R10 reset den_b", 32'(rden_b), 32'h0);
    endtask

    task automatic t_write_read_ft();
        pipe_a = 1'b0;
        wr_a(5, 2'b11, 18'h2A5A3);
        drv_a(1, 0, 2'b11, 5, '0); step();
        check("R4 ft read data", 32'(rdata_a), 32'(ref_mem[5]));
        check("R4 ft read den", 32'(rden_a), 32'h3);
        // partial write of the lower half only
        drv_a(1, 1, 2'b01, 5, 18'h1C3C5); ref_write(5, 2'b01, 18'h1C3C5); step();
        check("R11 write cycle undriven", 32'(rden_a), 32'h0);
        drv_a(1, 0, 2'b11, 5, '0); step();
        check("R3 lower-only write merge", 32'(rdata_a), 32'(ref_mem[5]));
        drv_a(1, 0, 2'b10, 5, '0); step();
        check("R2 upper-only read den", 32'(rden_a), 32'h2);
        check("R2 upper half value", 32'(rdata_a[17:9]), 32'(ref_mem[5][17:9]));
        drv_a(1, 0, 2'b01, 5, '0); step();
        check("R2 lower-only read den", 32'(rden_a), 32'h1);
        drv_a(0, 0, 2'b11, 0, '0);
        wr_a(6, 2'b11, 18'h0F00F);
        wr_a(7, 2'b11, 18'h3FFFF);
    endtask

    task automatic t_ignored_writes();
        // deselected by the active-high enable
        ce0_a_n = 1'b0; ce1_a = 1'b0; rw_a = 1'b0; ub_a_n = 1'b0; lb_a_n = 1'b0;
        addr_a = AW'(5); wdata_a = 18'h00000; step();
        check("R1 deselected den", 32'(rden_a), 32'h0);
        // both byte selects inactive
        drv_a(1, 1, 2'b00, 5, 18'h12345); step();
        drv_a(1, 0, 2'b11, 5, '0); step();
        check("R1/R3 ignored writes keep word", 32'(rdata_a), 32'(ref_mem[5]));
        ce0_a_n = 1'b1; ce1_a = 1'b1; rw_a = 1'b1; step();
        check("R1 read while deselected den", 32'(rden_a), 32'h0);
        drv_a(0, 0, 2'b11, 0, '0); step();
    endtask

    task automatic t_mode_compare();
        pipe_a = 1'b0; pipe_b = 1'b1;
        idle_both(); step(); step();
        for (int i = 0; i < 4; i++) begin
            int ad;
            ad = 5 + i;
            if (i < 3) begin
                drv_a(1, 0, 2'b11, ad, '0); drv_b(1, 0, 2'b11, ad, '0);
            end else begin
                idle_both();
            end
            step();
            if (i < 3) begin
                check("R4 ft stream data", 32'(rdata_a), 32'(ref_mem[ad]));
                check("R4 ft stream den", 32'(rden_a), 32'h3);
            end else begin
                check("R4 ft stream ends", 32'(rden_a), 32'h0);
            end
            if (i == 0) begin
                check("R5 pipe not yet driven", 32'(rden_b), 32'h0);
            end else begin
                check("R5 pipe one cycle later", 32'(rdata_b), 32'(ref_mem[ad-1]));
                check("R5 pipe den", 32'(rden_b), 32'h3);
            end
        end
        step();
        check("R5 pipe stream ends", 32'(rden_b), 32'h0);
    endtask

    task automatic t_pipe_bsel();
        pipe_b = 1'b1;
        drv_b(1, 0, 2'b11, 6, '0); step();
        drv_b(0, 0, 2'b10, 0, '0); step();
        check("R6 pipe single-stage byte select", 32'(rden_b), 32'h2);
        check("R6 pipe data", 32'(rdata_b[17:9]), 32'(ref_mem[6][17:9]));
        idle_both(); step(); step();
    endtask

    task automatic t_deselect_timing();
        pipe_a = 1'b0; pipe_b = 1'b1;
        drv_a(1, 0, 2'b11, 7, '0); drv_b(1, 0, 2'b11, 7, '0); step();
        check("R7 pipe reselect not yet", 32'(rden_b), 32'h0);
        step();
        check("R7 pipe reselect after two", 32'(rden_b), 32'h3);
        idle_both(); step();
        check("R7 ft deselect after one", 32'(rden_a), 32'h0);
        check("R7 pipe still driven", 32'(rden_b), 32'h3);
        step();
        check("R7 pipe deselect after two", 32'(rden_b), 32'h0);
    endtask

    task automatic t_oe_async();
        pipe_a = 1'b0;
        drv_a(1, 0, 2'b11, 6, '0); step();
        check("R8 baseline den", 32'(rden_a), 32'h3);
        #1 oe_a_n = 1'b1;
        #1 check("R8 oe high no clock", 32'(rden_a), 32'h0);
        #1 oe_a_n = 1'b0;
        #1 check("R8 oe restore", 32'(rden_a), 32'h3);
        @(negedge clk);
        idle_both(); step();
    endtask

    task automatic t_cross_port();
        pipe_a = 1'b0; pipe_b = 1'b0;
        drv_b(1, 1, 2'b11, 20, 18'h15555); ref_write(20, 2'b11, 18'h15555); step();
        drv_b(0, 0, 2'b11, 0, '0);
        drv_a(1, 0, 2'b11, 20, '0); step();
        check("R9 B write, A read", 32'(rdata_a), 32'(ref_mem[20]));
        // A writes upper, then B writes lower of the same word
        drv_a(1, 1, 2'b10, 30, 18'h3AB00); ref_write(30, 2'b10, 18'h3AB00); step();
        drv_a(0, 0, 2'b11, 0, '0);
        drv_b(1, 1, 2'b01, 30, 18'h000CD); ref_write(30, 2'b01, 18'h000CD); step();
        drv_a(1, 0, 2'b11, 30, '0); drv_b(1, 0, 2'b11, 30, '0); step();
        check("R9 merged halves via A", 32'(rdata_a), 32'(ref_mem[30]));
        check("R9 merged halves via B", 32'(rdata_b), 32'(ref_mem[30]));
        idle_both(); step();
    endtask

    initial begin
        #(8 * 20000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        oe_a_n = 1'b0; oe_b_n = 1'b0; pipe_a = 1'b0; pipe_b = 1'b0;
        idle_both();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        step();
        t_write_read_ft();
        t_ignored_writes();
        t_mode_compare();
        t_pipe_bsel();
        t_deselect_timing();
        t_oe_async();
        t_cross_port();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule